// File: doc/BRIEF.md
# Branch Redirect and Flush Sequencer

This block decides, for a small 32-bit in-order pipeline, where fetch goes after a conditional relative branch and how many cycles the pipeline pays for it. When the execute stage presents a branch (a one-cycle valid strobe), the block tests the condition operand for a nonzero value. It then forms either the branch target (branch PC plus the offset operand) or the sequential address (branch PC plus 4), and registers the result as the next PC.

A taken branch redirects fetch and runs a short refill sequence. The sequence is driven by a four-state machine:

- `ST_RUN` is the normal flow.
- `ST_DSLOT` is the single refill cycle of a taken branch that has its delay bit set. The instruction behind the branch stays in decode and completes, so only fetch is flushed.
- `ST_REFILL_A` and `ST_REFILL_B` are the two refill cycles of a taken branch with no delay slot. Fetch and decode are both flushed in each of them.

The transitions are:

- The run-to-slot transition happens on a taken branch with the delay bit set.
- The run-to-refill transition happens on a taken branch with the delay bit clear.
- The refill advance goes from A to B.
- The return to run happens from `ST_DSLOT` or `ST_REFILL_B`.

The bubble output is high in every refill cycle. The cost of a branch is therefore one cycle plus the number of bubble cycles that follow it. A branch that arrives while its delay slot is executing is illegal: the block raises an error pulse and treats that branch as not taken.

Top module: `branch_redirect_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `next_pc` is 0 and `redirect`, `flush_fetch`, `flush_decode`, `bubble` and `dslot_err` are all 0.
- R2: A branch accepted in `ST_RUN` is taken exactly when `cond_val` is nonzero; any single set bit, including bit 31, counts.
- R3: In the cycle after a taken branch, `next_pc` equals `pc_in + offset_val` modulo 2^32. The offset is a two's-complement value, so a negative offset moves the target backwards.
- R4: In the cycle after a not-taken branch, `next_pc` equals `pc_in + 4` and `bubble`, `flush_fetch` and `flush_decode` stay 0, giving a cost of 1 cycle.
- R5: A taken branch with `delay_bit`=1 is followed by exactly one cycle in which `bubble`=1 and `flush_fetch`=1 while `flush_decode`=0 (the delay-slot instruction is kept), giving a cost of 2 cycles.
- R6: A taken branch with `delay_bit`=0 is followed by exactly two cycles in which `bubble`, `flush_fetch` and `flush_decode` are all 1, giving a cost of 3 cycles.
- R7: `br_valid` during either refill cycle of a no-delay taken branch is ignored: `next_pc`, the flush and bubble sequence and `dslot_err` are unaffected.
- R8: `br_valid` in the delay-slot cycle makes `dslot_err` 1 for exactly the next cycle, loads `next_pc` with `pc_in + 4`, and starts no flush or bubble.
- R9: In a cycle with `br_valid`=0, `next_pc` keeps its value.
- R10: `redirect` is 1 only in the first cycle after a taken branch, for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A conditional branch is in execute this cycle |
| cond_val | input | 32 | Condition operand; branch taken when nonzero |
| offset_val | input | 32 | Two's-complement byte offset added to the branch PC |
| delay_bit | input | 1 | 1 = branch has a delay slot |
| pc_in | input | 32 | Address of the branch instruction |
| next_pc | output | 32 | Registered address at which execution continues |
| redirect | output | 1 | One-cycle pulse: fetch must restart at `next_pc` |
| flush_fetch | output | 1 | Discard fetch stage and prefetch contents this cycle |
| flush_decode | output | 1 | Discard decode stage contents this cycle |
| bubble | output | 1 | Refill cycle; counts toward the branch cost |
| dslot_err | output | 1 | One-cycle pulse after a branch seen in a delay slot |

## Verification
The bench builds the block with its defaults: a 32-bit data path and 4-byte instructions. With these widths, a branch near the top of the address space wraps its target past zero, a negative offset moves the target backwards, and a condition operand with only bit 31 set can be driven. A behavioural model in the bench tracks the remaining refill cycles and the delay-slot window, and is compared with every output on every clock. The stimulus includes directed branches placed in each refill cycle and in the delay slot, a reset in the middle of a refill, and a long run of randomized back-to-back branches.

// File: rtl/bu_pkg.sv
package bu_pkg;
    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_DSLOT    = 2'd1,
        ST_REFILL_A = 2'd2,
        ST_REFILL_B = 2'd3
    } bu_state_e;
endpackage

// File: rtl/bu_cond_eval.sv
module bu_cond_eval #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] cond_val,
    output logic            take
);
    // R2: the not-equal-to-zero test
    always_comb begin
        take = (cond_val != '0);
    end
endmodule

// File: rtl/bu_target_gen.sv
module bu_target_gen #(
    parameter int XLEN        = 32,
    parameter int INSTR_BYTES = 4
) (
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] offset_val,
    output logic [XLEN-1:0] jump_addr,
    output logic [XLEN-1:0] seq_addr
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

    always_comb begin
        jump_addr = pc_in + offset_val;   // R3: modulo 2^XLEN
        seq_addr  = pc_in + STEP;         // R4
    end
endmodule

// File: rtl/bu_seq_fsm.sv
module bu_seq_fsm
    import bu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic br_valid,
    input  logic take,
    input  logic delay_bit,
    output logic accept,
    output logic illegal,
    output logic redirect,
    output logic flush_fetch,
    output logic flush_decode,
    output logic bubble,
    output logic dslot_err
);
    bu_state_e state_q, state_d;
    logic      err_q;

    // branch acceptance: only in the normal flow; a branch in the slot is illegal
    always_comb begin
        accept  = br_valid && (state_q == ST_RUN);
        illegal = br_valid && (state_q == ST_DSLOT);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (accept && take) begin
                    state_d = delay_bit ? ST_DSLOT : ST_REFILL_A;
                end
            end
            ST_DSLOT:    state_d = ST_RUN;
            ST_REFILL_A: state_d = ST_REFILL_B;
            ST_REFILL_B: state_d = ST_RUN;
            default:     state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= illegal;
        end
    end

    // outputs
    always_comb begin
        redirect     = 1'b0;
        flush_fetch  = 1'b0;
        flush_decode = 1'b0;
        bubble       = 1'b0;
        unique case (state_q)
            ST_RUN: ;
            ST_DSLOT: begin
                redirect    = 1'b1;
                flush_fetch = 1'b1;
                bubble      = 1'b1;
            end
            ST_REFILL_A: begin
                redirect     = 1'b1;
                flush_fetch  = 1'b1;
                flush_decode = 1'b1;
                bubble       = 1'b1;
            end
            ST_REFILL_B: begin
                flush_fetch  = 1'b1;
                flush_decode = 1'b1;
                bubble       = 1'b1;
            end
            default: ;
        endcase
        dslot_err = err_q;
    end

    p_decode_flush_needs_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_decode |-> flush_fetch);

    p_nodelay_cost_three_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && take && !delay_bit) |=> bubble ##1 bubble ##1 !bubble);

    p_delay_cost_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && take && delay_bit) |=> (bubble && !flush_decode) ##1 !bubble);

    p_not_taken_cost_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !take) |=> !bubble);

    p_err_after_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && state_q == ST_DSLOT) |=> (dslot_err && !bubble));

    p_redirect_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect);
endmodule

// File: rtl/branch_redirect_unit.sv
module branch_redirect_unit #(
    parameter int XLEN        = 32,
    parameter int INSTR_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            br_valid,
    input  logic [XLEN-1:0] cond_val,
    input  logic [XLEN-1:0] offset_val,
    input  logic            delay_bit,
    input  logic [XLEN-1:0] pc_in,
    output logic [XLEN-1:0] next_pc,
    output logic            redirect,
    output logic            flush_fetch,
    output logic            flush_decode,
    output logic            bubble,
    output logic            dslot_err
);
    logic            take;
    logic            accept;
    logic            illegal;
    logic [XLEN-1:0] jump_addr;
    logic [XLEN-1:0] seq_addr;
    logic [XLEN-1:0] npc_q;

    bu_cond_eval #(.XLEN(XLEN)) u_cond (
        .cond_val (cond_val),
        .take     (take)
    );

    bu_target_gen #(.XLEN(XLEN), .INSTR_BYTES(INSTR_BYTES)) u_tgt (
        .pc_in      (pc_in),
        .offset_val (offset_val),
        .jump_addr  (jump_addr),
        .seq_addr   (seq_addr)
    );

    bu_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .br_valid     (br_valid),
        .take         (take),
        .delay_bit    (delay_bit),
        .accept       (accept),
        .illegal      (illegal),
        .redirect     (redirect),
        .flush_fetch  (flush_fetch),
        .flush_decode (flush_decode),
        .bubble       (bubble),
        .dslot_err    (dslot_err)
    );

    // next-PC register: loads on every evaluated branch, legal or not
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            npc_q <= '0;
        end else if (accept) begin
            npc_q <= take ? jump_addr : seq_addr;
        end else if (illegal) begin
            npc_q <= seq_addr;                  // R8: forced not-taken
        end
    end

    assign next_pc = npc_q;

    p_pc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> $stable(next_pc));

    p_taken_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && take) |=> (next_pc == $past(pc_in + offset_val)) && redirect);
endmodule

// File: tb/branch_redirect_unit_tb.sv
`timescale 1ns/1ps
module branch_redirect_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0;
    logic [31:0] cond_val = '0;
    logic [31:0] offset_val = '0;
    logic        delay_bit = 1'b0;
    logic [31:0] pc_in = '0;
    logic [31:0] next_pc;
    logic        redirect, flush_fetch, flush_decode, bubble, dslot_err;

    int errors = 0;
    int checks = 0;
    bit chk_en = 1'b0;

    always #4 clk = ~clk;

    branch_redirect_unit u_dut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .cond_val(cond_val),
        .offset_val(offset_val), .delay_bit(delay_bit), .pc_in(pc_in),
        .next_pc(next_pc), .redirect(redirect), .flush_fetch(flush_fetch),
        .flush_decode(flush_decode), .bubble(bubble), .dslot_err(dslot_err)
    );

    // behavioural reference: remaining refill cycles and the delay-slot window
    logic [31:0] e_pc;
    bit    e_ff, e_fd, e_bub, e_redir, e_err;
    int    rem;
    bit    in_slot;
    string ctx;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_pc = 0; e_ff = 0; e_fd = 0; e_bub = 0; e_redir = 0; e_err = 0;
            rem = 0; in_slot = 0; ctx = "R1";
        end else begin
            e_err = 0; e_redir = 0;
            if (br_valid && rem == 0) begin
                if (cond_val != 0) begin
                    e_pc = pc_in + offset_val;
                    e_redir = 1;
                    rem = delay_bit ? 1 : 2;
                    in_slot = delay_bit;
                    ctx = delay_bit ? "R2 R3 R5 R10" : "R2 R3 R6 R10";
                end else begin
                    e_pc = pc_in + 32'd4;
                    ctx = "R2 R4";
                end
            end else if (br_valid && in_slot && rem > 0) begin
                e_pc = pc_in + 32'd4;
                e_err = 1; rem = 0; in_slot = 0;
                ctx = "R8";
            end else begin
                ctx = (rem > 0) ? (br_valid ? "R7" : "R5 R6") : "R9";
                if (rem > 0) rem = rem - 1;
                if (rem == 0) in_slot = 0;
            end
            e_bub = (rem > 0);
            e_ff  = (rem > 0);
            e_fd  = (rem > 0) && !in_slot;
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string sig);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", ctx, sig, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en) begin
            check(next_pc, e_pc, "next_pc");
            check({31'd0, redirect}, {31'd0, e_redir}, "redirect");
            check({31'd0, flush_fetch}, {31'd0, e_ff}, "flush_fetch");
            check({31'd0, flush_decode}, {31'd0, e_fd}, "flush_decode");
            check({31'd0, bubble}, {31'd0, e_bub}, "bubble");
            check({31'd0, dslot_err}, {31'd0, e_err}, "dslot_err");
        end
    end

    task automatic step(input bit v, input logic [31:0] c, input logic [31:0] o,
                        input bit d, input logic [31:0] p);
        br_valid = v; cond_val = c; offset_val = o; delay_bit = d; pc_in = p;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 32'hDEAD, 32'h44, 1, 32'h7000);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        repeat (2) @(negedge clk);
        chk_en = 1'b1;                        // R1: outputs in reset
        @(negedge clk); #1 rst_n = 1'b1;
        idle(3);                              // R1, R9
        step(1, 0, 32'h100, 0, 32'h40);       // R4 not taken
        idle(2);
        step(1, 5, 32'h100, 1, 32'h40);       // R5 delayed taken
        idle(3);
        step(1, 32'h8000_0000, 32'hFFFF_FFF0, 0, 32'h200); // R2 R3 R6 negative offset
        idle(3);
        step(1, 1, 32'h80, 0, 32'h300);       // R6
        step(1, 1, 32'h999, 1, 32'h1000);     // R7 ignored in refill A
        step(1, 0, 32'h4, 0, 32'h2000);       // R7 ignored in refill B
        idle(2);
        step(1, 1, 32'h40, 1, 32'h500);       // delayed taken
        step(1, 1, 32'h1000, 1, 32'h504);     // R8 branch in delay slot
        idle(3);
        step(1, 1, 32'h20, 1, 32'hFFFF_FFF0); // R3 wrap past zero
        idle(2);
        step(1, 0, 32'h8, 1, 32'h600);        // R4 back-to-back
        step(1, 7, 32'h8, 0, 32'h604);
        #1 rst_n = 1'b0;                      // R1 reset during refill
        @(negedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 3) != 0,
                 (($urandom % 3) == 0) ? 32'd0 : (32'd1 << ($urandom % 32)),
                 $urandom, $urandom % 2, $urandom);
        end
        idle(3);
        summary();
    end
endmodule